// File: doc/BRIEF.md
# Serial FPGA Configuration Sequencer

This block brings a target FPGA from an unconfigured state to a running one over a slave-serial link. It drives three pins toward the target: a program request, a configuration clock and a serial data line. It watches two status pins that come back: the target's initialisation flag and its configuration-complete flag. A single-cycle start pulse launches the sequence. The block asserts the program request and waits for the initialisation flag to drop. It then releases the request and waits for the flag to come back up.

Once the target is ready, the block takes configuration bytes from a valid/ready byte stream and sends each one most-significant bit first. Every bit goes through a fixed four-phase pin pattern, one system clock per phase. After the byte count latched at start reaches zero, the block waits for the completion flag. Each of the three waits has its own timeout. The timeouts are counted in millisecond ticks, and a prescaler parameter sets how many system clocks make one tick. The block ends either with a success flag or with a two-bit error code that names the wait that expired.

Top module: `serial_cfg_loader`

## Requirements
- R1: Out of reset and whenever `busy` is low, the program pin is at its inactive level, `cfg_cclk` and `cfg_din` are both 1, and `byte_ready` is 0.
- R2: With `PROG_ACTIVE_HIGH` = 0 the program pin is active when 0. With `PROG_ACTIVE_HIGH` = 1 it is active when 1.
- R3: After start, the program pin stays active until the synchronised init input reads 0. If that does not happen within `INIT_FALL_TICKS`×`TICK_DIV` clocks, the sequence ends with `err_code` = 1.
- R4: After init falls, the program pin is released and the block waits for init to read 1. If that does not happen within `INIT_RISE_TICKS` ticks, the sequence ends with `err_code` = 2.
- R5: Each bit takes four consecutive clocks with these (`cfg_cclk`,`cfg_din`) values: (0,1), (0,bit), (1,bit), (1,1). `cfg_din` therefore never changes in the cycle where `cfg_cclk` rises.
- R6: Bytes are sent bit 7 first. `byte_ready` is high only while the block waits for a byte. After a byte is accepted, the next byte is accepted no sooner than 32 clocks later.
- R7: The `cfg_len` value is latched at start, and exactly that many bytes are sent. With a length of 0, the block goes straight from init high to the completion wait.
- R8: After the last byte, when `cfg_done` reads 1 the block raises `ok` with `err_code` = 0. If it does not read 1 within `DONE_TICKS` ticks, the sequence ends with `err_code` = 3.
- R9: `cfg_init` and `cfg_done` pass through two synchronising flops. A change in init that is driven before clock edge k is acted on at edge k+2.
- R10: A start pulse while `busy` is high is ignored, including its `cfg_len` value.
- R11: `ok` and `err_code` keep their values while idle until the next accepted start, which clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle launch request |
| cfg_len | input | LEN_W | Number of bytes to send, latched at start |
| byte_data | input | 8 | Configuration byte offered |
| byte_valid | input | 1 | `byte_data` is valid |
| byte_ready | output | 1 | Block accepts a byte this cycle |
| cfg_prog | output | 1 | Program request to target, polarity per `PROG_ACTIVE_HIGH` |
| cfg_cclk | output | 1 | Configuration clock to target |
| cfg_din | output | 1 | Serial configuration data to target |
| cfg_init | input | 1 | Target initialisation flag (asynchronous) |
| cfg_done | input | 1 | Target configuration-complete flag (asynchronous) |
| busy | output | 1 | Sequence in progress |
| ok | output | 1 | Last sequence succeeded |
| err_code | output | 2 | 0 none, 1 init never fell, 2 init never rose, 3 done never rose |

## Verification
The hardest cases to reach are the three failure points. Each one needs a target that cooperates up to a chosen step and then goes silent. The bench therefore models the target with three enable knobs, one per response, and disables one at a time. A small prescaler keeps each timeout to a few dozen clocks. The synchroniser latency is measured by taking over the init pin by hand and flipping it at a known edge.

// File: rtl/scl_pkg.sv
package scl_pkg;

    localparam int BYTE_W = 8;
    localparam int PHASES = 4;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_INIT_LOW  = 3'd1,
        ST_INIT_HIGH = 3'd2,
        ST_FETCH     = 3'd3,
        ST_SHIFT     = 3'd4,
        ST_DONE_WAIT = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        ERR_NONE      = 2'd0,
        ERR_INIT_FALL = 2'd1,
        ERR_INIT_RISE = 2'd2,
        ERR_DONE      = 2'd3
    } seq_err_e;

    typedef struct packed {
        logic cclk;
        logic din;
    } pin_pair_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

    // Pin pattern for one phase of a bit: data parked high around the clock pulse.
    function automatic pin_pair_t phase_pins(input logic [1:0] ph, input logic bitv);
        pin_pair_t p;
        case (ph)
            2'd0:    begin p.cclk = 1'b0; p.din = 1'b1; end
            2'd1:    begin p.cclk = 1'b0; p.din = bitv; end
            2'd2:    begin p.cclk = 1'b1; p.din = bitv; end
            default: begin p.cclk = 1'b1; p.din = 1'b1; end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
    parameter int          WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1_q[i] <= RST_VAL[i];
                stage2_q[i] <= RST_VAL[i];
            end else begin
                stage1_q[i] <= d_async[i];
                stage2_q[i] <= stage1_q[i];
            end
        end
    end

    assign d_sync = stage2_q;
endmodule

// File: rtl/scl_timer.sv
module scl_timer #(
    parameter int TICK_DIV = 100000,
    parameter int LIM_W    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic [LIM_W-1:0] limit,
    output logic             expired
);
    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

    logic [PRE_W-1:0] pre_q;
    logic [LIM_W-1:0] ticks_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre_q   <= '0;
            ticks_q <= '0;
        end else if (en) begin
            if (pre_q == PRE_LAST) begin
                pre_q <= '0;
                if (ticks_q != limit) ticks_q <= ticks_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    assign expired = (ticks_q == limit);
endmodule

// File: rtl/scl_serializer.sv
module scl_serializer
    import scl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] data,
    output logic              active,
    output logic              last,
    output logic              cclk,
    output logic              din
);
    localparam int IDX_W = $clog2(BYTE_W);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BYTE_W - 1);

    logic [BYTE_W-1:0] sh_q;
    logic [1:0]        ph_q;
    logic [IDX_W-1:0]  idx_q;
    logic              act_q;
    pin_pair_t         pins;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            ph_q  <= '0;
            idx_q <= '0;
            act_q <= 1'b0;
        end else if (load && !act_q) begin
            sh_q  <= data;
            ph_q  <= '0;
            idx_q <= '0;
            act_q <= 1'b1;
        end else if (act_q) begin
            ph_q <= ph_q + 1'b1;
            if (ph_q == 2'd3) begin
                sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
                idx_q <= idx_q + 1'b1;
                if (idx_q == IDX_LAST) act_q <= 1'b0;
            end
        end
    end

    always_comb begin
        if (act_q) pins = phase_pins(ph_q, sh_q[BYTE_W-1]);
        else       pins = '{cclk: 1'b1, din: 1'b1};
    end

    assign active = act_q;
    assign last   = act_q && (ph_q == 2'd3) && (idx_q == IDX_LAST);
    assign cclk   = pins.cclk;
    assign din    = pins.din;
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
    import scl_pkg::*;
#(
    parameter bit PROG_ACTIVE_HIGH = 1'b0,
    parameter int TICK_DIV         = 100000,
    parameter int INIT_FALL_TICKS  = 3,
    parameter int INIT_RISE_TICKS  = 6,
    parameter int DONE_TICKS       = 6,
    parameter int LEN_W            = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [7:0]       byte_data,
    input  logic             byte_valid,
    output logic             byte_ready,
    output logic             cfg_prog,
    output logic             cfg_cclk,
    output logic             cfg_din,
    input  logic             cfg_init,
    input  logic             cfg_done,
    output logic             busy,
    output logic             ok,
    output logic [1:0]       err_code
);
    localparam int LIM_MAX = max3(INIT_FALL_TICKS, INIT_RISE_TICKS, DONE_TICKS);
    localparam int TICK_W  = $clog2(LIM_MAX + 1);

    seq_state_e        state_q;
    seq_err_e          err_q;
    logic              ok_q;
    logic [LEN_W-1:0]  left_q;

    logic [1:0]        status_sync;
    logic              init_s;
    logic              done_s;

    logic              tmr_clr;
    logic              tmr_en;
    logic [TICK_W-1:0] tmr_lim;
    logic              tmr_exp;

    logic              ser_load;
    logic              ser_active;
    logic              ser_last;
    logic              ser_cclk;
    logic              ser_din;
    logic              prog_act;

    scl_sync #(
        .WIDTH   (2),
        .RST_VAL (2'b01)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async ({cfg_done, cfg_init}),
        .d_sync  (status_sync)
    );
    assign init_s = status_sync[0];
    assign done_s = status_sync[1];

    always_comb begin
        tmr_en  = 1'b0;
        tmr_lim = TICK_W'(INIT_FALL_TICKS);
        case (state_q)
            ST_INIT_LOW:  begin tmr_en = 1'b1; tmr_lim = TICK_W'(INIT_FALL_TICKS); end
            ST_INIT_HIGH: begin tmr_en = 1'b1; tmr_lim = TICK_W'(INIT_RISE_TICKS); end
            ST_DONE_WAIT: begin tmr_en = 1'b1; tmr_lim = TICK_W'(DONE_TICKS);      end
            default:      begin tmr_en = 1'b0; end
        endcase
        tmr_clr = !tmr_en
               || (state_q == ST_INIT_LOW  && !init_s)
               || (state_q == ST_INIT_HIGH &&  init_s);
    end

    scl_timer #(
        .TICK_DIV (TICK_DIV),
        .LIM_W    (TICK_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr     (tmr_clr),
        .en      (tmr_en),
        .limit   (tmr_lim),
        .expired (tmr_exp)
    );

    assign ser_load = (state_q == ST_FETCH) && byte_valid;

    scl_serializer u_ser (
        .clk    (clk),
        .rst    (rst),
        .load   (ser_load),
        .data   (byte_data),
        .active (ser_active),
        .last   (ser_last),
        .cclk   (ser_cclk),
        .din    (ser_din)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            err_q   <= ERR_NONE;
            ok_q    <= 1'b0;
            left_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        left_q  <= cfg_len;
                        err_q   <= ERR_NONE;
                        ok_q    <= 1'b0;
                        state_q <= ST_INIT_LOW;
                    end
                end
                ST_INIT_LOW: begin
                    if (!init_s) begin
                        state_q <= ST_INIT_HIGH;
                    end else if (tmr_exp) begin
                        err_q   <= ERR_INIT_FALL;
                        state_q <= ST_IDLE;
                    end
                end
                ST_INIT_HIGH: begin
                    if (init_s) begin
                        state_q <= (left_q == '0) ? ST_DONE_WAIT : ST_FETCH;
                    end else if (tmr_exp) begin
                        err_q   <= ERR_INIT_RISE;
                        state_q <= ST_IDLE;
                    end
                end
                ST_FETCH: begin
                    if (byte_valid) state_q <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (ser_last) begin
                        left_q  <= left_q - 1'b1;
                        state_q <= (left_q == LEN_W'(1)) ? ST_DONE_WAIT : ST_FETCH;
                    end
                end
                ST_DONE_WAIT: begin
                    if (done_s) begin
                        ok_q    <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (tmr_exp) begin
                        err_q   <= ERR_DONE;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign prog_act   = (state_q == ST_INIT_LOW);
    assign cfg_prog   = PROG_ACTIVE_HIGH ? prog_act : !prog_act;
    assign cfg_cclk   = ser_active ? ser_cclk : 1'b1;
    assign cfg_din    = ser_active ? ser_din  : 1'b1;
    assign byte_ready = (state_q == ST_FETCH);
    assign busy       = (state_q != ST_IDLE);
    assign ok         = ok_q;
    assign err_code   = err_q;
endmodule

// File: rtl/scl_checker.sv
module scl_checker #(
    parameter bit PROG_ACTIVE_HIGH = 1'b0
) (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       busy,
    input logic       ok,
    input logic [1:0] err_code,
    input logic       byte_ready,
    input logic       cfg_prog,
    input logic       cfg_cclk,
    input logic       cfg_din
);
    logic prog_on;
    assign prog_on = (cfg_prog == PROG_ACTIVE_HIGH);

    a_r1_idle_pins: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (cfg_cclk && cfg_din && !prog_on && !byte_ready));

    a_r2_prog_only_busy: assert property (@(posedge clk) disable iff (rst)
        prog_on |-> busy);

    a_r5_din_high_on_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(cfg_cclk) |-> cfg_din);

    a_r5_din_held_on_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_cclk) |-> $stable(cfg_din));

    a_r6_ready_pins_parked: assert property (@(posedge clk) disable iff (rst)
        byte_ready |-> (cfg_cclk && cfg_din && !prog_on));

    a_r8_ok_no_error: assert property (@(posedge clk) disable iff (rst)
        ok |-> (err_code == 2'd0));

    a_r11_result_held: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(err_code) && $stable(ok)));
endmodule

bind serial_cfg_loader scl_checker #(
    .PROG_ACTIVE_HIGH (PROG_ACTIVE_HIGH)
) u_scl_checker (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .busy       (busy),
    .ok         (ok),
    .err_code   (err_code),
    .byte_ready (byte_ready),
    .cfg_prog   (cfg_prog),
    .cfg_cclk   (cfg_cclk),
    .cfg_din    (cfg_din)
);

// File: tb/test_serial_cfg_loader.sv
`timescale 1ns/1ps
module test_serial_cfg_loader;
    localparam int DIV = 4;
    localparam int LF  = 3;
    localparam int LR  = 4;
    localparam int LD  = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] len_in = '0;
    logic [7:0] byte_data = '0;
    logic       byte_valid = 1'b0;
    logic       byte_ready;
    logic       cfg_prog, cfg_cclk, cfg_din;
    logic       busy, ok;
    logic [1:0] err_code;

    logic tgt_init = 1'b1, tgt_done = 1'b0;
    logic manual = 1'b0, man_init = 1'b1, man_done = 1'b0;
    wire  cfg_init = manual ? man_init : tgt_init;
    wire  cfg_done = manual ? man_done : tgt_done;

    logic       start_hi = 1'b0;
    logic       hi_ready, hi_prog, hi_cclk, hi_din, hi_busy, hi_ok;
    logic [1:0] hi_err;

    int checks = 0, fails = 0, cyc_total = 0;

    always #2 clk = ~clk;

    serial_cfg_loader #(.PROG_ACTIVE_HIGH(1'b0), .TICK_DIV(DIV), .INIT_FALL_TICKS(LF),
        .INIT_RISE_TICKS(LR), .DONE_TICKS(LD), .LEN_W(8)) i_serial_cfg_loader (
        .clk(clk), .rst(rst), .start(start), .cfg_len(len_in), .byte_data(byte_data),
        .byte_valid(byte_valid), .byte_ready(byte_ready), .cfg_prog(cfg_prog),
        .cfg_cclk(cfg_cclk), .cfg_din(cfg_din), .cfg_init(cfg_init), .cfg_done(cfg_done),
        .busy(busy), .ok(ok), .err_code(err_code));

    serial_cfg_loader #(.PROG_ACTIVE_HIGH(1'b1), .TICK_DIV(DIV), .INIT_FALL_TICKS(LF),
        .INIT_RISE_TICKS(LR), .DONE_TICKS(LD), .LEN_W(8)) i_serial_cfg_loader_hi (
        .clk(clk), .rst(rst), .start(start_hi), .cfg_len(8'd1), .byte_data(8'h00),
        .byte_valid(1'b0), .byte_ready(hi_ready), .cfg_prog(hi_prog),
        .cfg_cclk(hi_cclk), .cfg_din(hi_din), .cfg_init(1'b1), .cfg_done(1'b0),
        .busy(hi_busy), .ok(hi_ok), .err_code(hi_err));

    task automatic chk(input bit good, input string req, input int act, input int exp);
        checks++;
        if (!good) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Target model
    bit   fall_en = 1, rise_en = 1, done_en = 1, armed = 0;
    int   dly = 0, ddly = 0, exp_len = 0, rx_n = 0, bit_n = 0;
    logic prev_cclk = 1'b1;
    logic [7:0] rx_sh = '0;
    logic [7:0] rxbuf [0:7];

    always @(negedge clk) begin
        logic prog_on;
        logic [7:0] nsh;
        prog_on = (cfg_prog == 1'b0);
        if (prog_on) begin rx_n = 0; bit_n = 0; armed = 0; tgt_done = 1'b0; ddly = 0; end
        if (!manual) begin
            if (prog_on && tgt_init) begin
                if (fall_en) begin dly++; if (dly >= 2) begin tgt_init = 1'b0; dly = 0; end end
            end else if (!prog_on && !tgt_init) begin
                if (rise_en) begin dly++; if (dly >= 3) begin tgt_init = 1'b1; dly = 0; armed = 1; end end
            end else dly = 0;
            if (armed && rx_n == exp_len && done_en && !tgt_done) begin
                ddly++; if (ddly >= 2) tgt_done = 1'b1;
            end
        end
        if (cfg_cclk && !prev_cclk) begin
            nsh = {rx_sh[6:0], cfg_din};
            rx_sh = nsh;
            bit_n++;
            if (bit_n == 8) begin
                if (rx_n < 8) rxbuf[rx_n] = nsh;
                rx_n++;
                bit_n = 0;
            end
        end
        prev_cclk = cfg_cclk;
    end

    // Byte source with gap and phase recorder
    logic [7:0] src [0:7];
    int   src_n = 0, src_idx = 0, gap = 0, gap_cnt = 0, gap_bad = 0, rec_n = 0;
    bit   pend = 0, gap_on = 0, rec_on = 0, rec_arm = 0;
    logic [1:0] rec [0:31];

    always @(negedge clk) begin
        if (pend) begin
            src_idx++; pend = 0; gap_on = 1; gap = 0;
            if (rec_arm) begin rec_on = 1; rec_n = 0; rec_arm = 0; end
        end
        if (rec_on) begin
            rec[rec_n] = {cfg_cclk, cfg_din};
            rec_n++;
            if (rec_n == 32) rec_on = 0;
        end
        if (gap_on) begin
            if (byte_ready) begin
                gap_on = 0; gap_cnt++;
                if (gap != 32) gap_bad++;
            end else if (!busy) gap_on = 0;
            else gap++;
        end
        byte_valid = (src_idx < src_n);
        byte_data  = (src_idx < src_n) ? src[src_idx] : 8'h00;
        pend = byte_valid && byte_ready;
    end

    task automatic run(input int n, input bit fe, input bit fr, input bit fd, output int cyc);
        src_idx = 0; src_n = n; exp_len = n;
        fall_en = fe; rise_en = fr; done_en = fd;
        rec_arm = 1; gap_cnt = 0; gap_bad = 0;
        @(negedge clk); start = 1'b1; len_in = 8'(n);
        @(negedge clk); start = 1'b0;
        cyc = 1;
        while (busy && cyc < 5000) begin @(negedge clk); cyc++; end
    endtask

    task automatic check_bytes(input int n, input string req);
        int bad;
        bad = 0;
        for (int i = 0; i < n; i++) if (rxbuf[i] !== src[i]) bad++;
        chk(rx_n == n && bad == 0, req, rx_n * 100 + bad, n * 100);
    endtask

    task automatic check_phases(input logic [7:0] b);
        int bad;
        bad = 0;
        for (int i = 0; i < 8; i++) begin
            logic bv;
            bv = b[7 - i];
            if (rec[4*i]   !== 2'b01)      bad++;
            if (rec[4*i+1] !== {1'b0, bv}) bad++;
            if (rec[4*i+2] !== {1'b1, bv}) bad++;
            if (rec[4*i+3] !== 2'b11)      bad++;
        end
        chk(bad == 0, "R5 four-phase bit pattern", bad, 0);
    endtask

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!busy && cfg_prog && cfg_cclk && cfg_din && !byte_ready && !ok && err_code == 0,
            "R1 reset levels", {busy, cfg_prog, cfg_cclk, cfg_din, byte_ready}, 5'b01110);
        chk(!hi_prog, "R2 active-high idle level", hi_prog, 0);

        // Success sweep over lengths and patterns
        for (int n = 1; n <= 4; n++) begin
            for (int i = 0; i < n; i++) src[i] = 8'((n * 37 + i * 91) ^ (i[0] ? 8'hFF : 8'h5A));
            if (n == 2) begin src[0] = 8'h00; src[1] = 8'hFF; end
            run(n, 1, 1, 1, cyc);
            chk(ok && err_code == 0, "R8 success flag", {ok, err_code}, 3'b100);
            check_bytes(n, "R6 msb-first bytes / R7 count");
            check_phases(src[0]);
            chk(gap_bad == 0 && gap_cnt == n - 1, "R6 32-clock byte spacing", gap_cnt * 10 + gap_bad, (n - 1) * 10);
        end

        // R7 zero length
        run(0, 1, 1, 1, cyc);
        chk(ok && rx_n == 0 && err_code == 0, "R7 zero length", rx_n, 0);

        // R10 start while busy ignored
        src[0] = 8'hC3; src[1] = 8'h3C;
        fork
            run(2, 1, 1, 1, cyc);
            begin
                repeat (30) @(negedge clk);
                start = 1'b1; len_in = 8'd5;
                @(negedge clk); start = 1'b0;
            end
        join
        chk(ok && rx_n == 2, "R10 start ignored while busy", rx_n, 2);
        check_bytes(2, "R10 bytes unchanged");

        // R3 init never falls
        run(1, 0, 1, 1, cyc);
        chk(err_code == 1 && !ok, "R3 init-fall timeout code", err_code, 1);
        chk(cyc >= LF * DIV && cyc <= LF * DIV + 4, "R3 timeout length", cyc, LF * DIV + 2);
        repeat (10) @(negedge clk);
        chk(err_code == 1 && !busy, "R11 error held while idle", err_code, 1);
        src[0] = 8'h81;
        run(1, 1, 1, 1, cyc);
        chk(ok && err_code == 0, "R11 new start clears error", err_code, 0);

        // R4 init never rises
        tgt_init = 1'b1;
        run(1, 1, 0, 1, cyc);
        chk(err_code == 2 && !ok, "R4 init-rise timeout code", err_code, 2);
        chk(cfg_prog == 1'b1, "R4 program released", cfg_prog, 1);
        tgt_init = 1'b1; dly = 0;
        repeat (4) @(negedge clk);

        // R8 done never rises
        src[0] = 8'h5E;
        run(1, 1, 1, 0, cyc);
        chk(err_code == 3 && !ok, "R8 done timeout code", err_code, 3);
        check_bytes(1, "R8 bytes before done timeout");

        // R9 synchroniser latency, init driven by hand
        manual = 1'b1; man_init = 1'b1; man_done = 1'b0;
        @(negedge clk); start = 1'b1; len_in = 8'd0;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        chk(cfg_prog == 1'b0, "R3 program held active", cfg_prog, 0);
        man_init = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk(cfg_prog == 1'b0, "R9 still active after two edges", cfg_prog, 0);
        @(posedge clk); @(negedge clk);
        chk(cfg_prog == 1'b1, "R9 released at third edge", cfg_prog, 1);
        man_init = 1'b1;
        repeat (5) @(negedge clk);
        man_done = 1'b1;
        cyc = 0;
        while (busy && cyc < 200) begin @(negedge clk); cyc++; end
        chk(ok && err_code == 0, "R9 done seen through synchroniser", {ok, err_code}, 3'b100);
        manual = 1'b0; tgt_init = 1'b1;

        // R2 active-high polarity instance
        @(negedge clk); start_hi = 1'b1;
        @(negedge clk); start_hi = 1'b0;
        chk(hi_prog == 1'b1 && hi_busy, "R2 active-high asserted", hi_prog, 1);
        cyc = 0;
        while (hi_busy && cyc < 200) begin @(negedge clk); cyc++; end
        chk(hi_err == 1 && hi_prog == 1'b0, "R2 active-high released on timeout", hi_err, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc_total, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule